// File: doc/BRIEF.md
# Redundant Store Commit Comparator

Two redundant copies of one program thread run on the same core, and each copy retires its stores as address/data pairs. This block sits where those stores leave the replicated region. Stores retired by the leading copy are held in an ordered queue. When the trailing copy retires its next store, that store is compared with the oldest held leading store. A store goes to memory only when both its address and its data agree in the two copies. Instructions other than stores are never compared.

The two copies do not run in lockstep. Matching stores may retire many cycles apart, so pairing depends only on retirement order and not on timing. A disagreement in the address or the data means a transient fault was caught. The fault output then rises and stays high until reset, and from that point no further store reaches memory. The leading copy is held back when the queue is full, and the trailing copy is held back while the memory-side output register is occupied and not draining.

Top module: `store_pair_checker`

## Requirements
- R1: During and after reset the block presents `mem_valid`=0, `fault`=0, `lead_ready`=1 and `trail_ready`=0.
- R2: A leading store is taken on each clock edge where `lead_valid` and `lead_ready` are both 1. `lead_ready` is 0 exactly when DEPTH leading stores are waiting.
- R3: `trail_ready` is 1 only when at least one leading store is waiting and the output slot is free (`mem_valid`=0 or `mem_ready`=1).
- R4: Pairing follows program order. Each accepted trailing store is compared with the oldest waiting leading store, and that leading store is then removed from the queue.
- R5: When both address and data agree, `mem_valid` is 1 from the cycle after the trailing store is accepted, and `mem_addr`/`mem_data` carry the agreed store.
- R6: When address or data differ, `fault` is 1 from the cycle after the trailing store is accepted, and that store is not sent to memory.
- R7: Once `fault` is 1 it stays 1 until reset, and no new store is presented to memory afterwards.
- R8: While `mem_valid`=1 and `mem_ready`=0, `mem_valid`, `mem_addr` and `mem_data` hold their values.
- R9: A leading store that has no trailing partner is never sent to memory, and a trailing store offered while no leading store waits is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lead_valid | input | 1 | Leading copy offers a retired store |
| lead_ready | output | 1 | Queue can take a leading store |
| lead_addr | input | AW | Leading store address |
| lead_data | input | DW | Leading store data |
| trail_valid | input | 1 | Trailing copy offers a retired store |
| trail_ready | output | 1 | Trailing store can be compared this cycle |
| trail_addr | input | AW | Trailing store address |
| trail_data | input | DW | Trailing store data |
| mem_valid | output | 1 | Verified store presented to memory |
| mem_ready | input | 1 | Memory takes the presented store |
| mem_addr | output | AW | Verified store address |
| mem_data | output | DW | Verified store data |
| fault | output | 1 | Sticky flag: a store pair disagreed |

## Verification
The handshake readies are combinational. They are sampled in the same cycle as the stimulus, half a period after the edge that changed the queue or the output slot. A compare result shows up one edge after the trailing store is taken: `mem_valid` with the verified store on a match, `fault` on a mismatch. The bench drives every input at the falling edge, so each input is stable for the next rising edge. It samples results at the falling edge after that rising edge. A held output is checked again one full cycle later to confirm that it has not moved.

// File: rtl/spc_pkg.sv
package spc_pkg;

   typedef enum logic [1:0] {
      VERDICT_NONE   = 2'd0,
      VERDICT_AGREE  = 2'd1,
      VERDICT_DIFFER = 2'd2
   } verdict_e;

   function automatic int lane_count(input int width, input int lane_w);
      return (width + lane_w - 1) / lane_w;
   endfunction

endpackage

// File: rtl/spc_fifo.sv
module spc_fifo #(
   parameter int W     = 64,
   parameter int DEPTH = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         push,
   input  logic [W-1:0]                 din,
   input  logic                         pop,
   output logic [W-1:0]                 dout,
   output logic                         full,
   output logic                         empty,
   output logic [$clog2(DEPTH+1)-1:0]   count
);
   localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW   = $clog2(DEPTH + 1);
   localparam bit POW2 = ((1 << PW) == DEPTH);

   logic [W-1:0]  slots [DEPTH];
   logic [PW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CW-1:0] occ;
   logic          do_push, do_pop;

   assign full    = (occ == CW'(DEPTH));
   assign empty   = (occ == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = slots[rd_ptr];
   assign count   = occ;

   generate
      if (POW2) begin : g_pow2_wrap
         assign wr_nxt = wr_ptr + PW'(1);
         assign rd_nxt = rd_ptr + PW'(1);
      end else begin : g_cmp_wrap
         assign wr_nxt = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + PW'(1);
         assign rd_nxt = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + PW'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (do_push) slots[wr_ptr] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         occ    <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         case ({do_push, do_pop})
            2'b10:   occ <= occ + CW'(1);
            2'b01:   occ <= occ - CW'(1);
            default: occ <= occ;
         endcase
      end
   end
endmodule

// File: rtl/spc_match.sv
module spc_match
   import spc_pkg::*;
#(
   parameter int AW     = 32,
   parameter int DW     = 32,
   parameter int LANE_W = 8
) (
   input  logic          check,
   input  logic [AW-1:0] a_addr,
   input  logic [DW-1:0] a_data,
   input  logic [AW-1:0] b_addr,
   input  logic [DW-1:0] b_data,
   output verdict_e      verdict
);
   localparam int NL  = lane_count(DW, LANE_W);
   localparam int PDW = NL * LANE_W;

   logic [PDW-1:0] pa, pb;
   logic [NL-1:0]  lane_eq;
   logic           addr_eq;

   assign pa      = PDW'(a_data);
   assign pb      = PDW'(b_data);
   assign addr_eq = (a_addr == b_addr);

   generate
      for (genvar i = 0; i < NL; i++) begin : g_lane
         assign lane_eq[i] = (pa[i*LANE_W +: LANE_W] == pb[i*LANE_W +: LANE_W]);
      end
   endgenerate

   always_comb begin
      if (!check)                   verdict = VERDICT_NONE;
      else if (addr_eq && &lane_eq) verdict = VERDICT_AGREE;
      else                          verdict = VERDICT_DIFFER;
   end
endmodule

// File: rtl/spc_release.sv
module spc_release #(
   parameter int AW = 32,
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] addr_in,
   input  logic [DW-1:0] data_in,
   input  logic          mem_ready,
   output logic          mem_valid,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_data,
   output logic          slot_free
);
   assign slot_free = !mem_valid || mem_ready;

   always_ff @(posedge clk) begin
      if (!rst_n)         mem_valid <= 1'b0;
      else if (load)      mem_valid <= 1'b1;
      else if (mem_ready) mem_valid <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mem_addr <= '0;
         mem_data <= '0;
      end else if (load) begin
         mem_addr <= addr_in;
         mem_data <= data_in;
      end
   end
endmodule

// File: rtl/store_pair_checker.sv
module store_pair_checker
   import spc_pkg::*;
#(
   parameter int AW     = 32,
   parameter int DW     = 32,
   parameter int DEPTH  = 4,
   parameter int LANE_W = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          lead_valid,
   output logic          lead_ready,
   input  logic [AW-1:0] lead_addr,
   input  logic [DW-1:0] lead_data,
   input  logic          trail_valid,
   output logic          trail_ready,
   input  logic [AW-1:0] trail_addr,
   input  logic [DW-1:0] trail_data,
   output logic          mem_valid,
   input  logic          mem_ready,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_data,
   output logic          fault
);
   localparam int EW = AW + DW;
   localparam int CW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("store_pair_checker: DEPTH must be at least 2");
      end
      if (AW < 1 || DW < 1) begin : g_bad_width
         $error("store_pair_checker: AW and DW must be positive");
      end
      if (LANE_W < 1 || LANE_W > DW) begin : g_bad_lane
         $error("store_pair_checker: LANE_W must lie in 1..DW");
      end
   endgenerate

   logic [EW-1:0] head;
   logic [AW-1:0] head_addr;
   logic [DW-1:0] head_data;
   logic          q_full, q_empty, slot_free, pop, load;
   logic [CW-1:0] occ;
   verdict_e      verdict;

   assign head_addr   = head[EW-1:DW];
   assign head_data   = head[DW-1:0];
   assign lead_ready  = !q_full;
   assign trail_ready = !q_empty && slot_free;
   assign pop         = trail_valid && trail_ready;
   assign load        = (verdict == VERDICT_AGREE) && !fault;

   spc_fifo #(.W(EW), .DEPTH(DEPTH)) u_queue (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (lead_valid),
      .din   ({lead_addr, lead_data}),
      .pop   (pop),
      .dout  (head),
      .full  (q_full),
      .empty (q_empty),
      .count (occ)
   );

   spc_match #(.AW(AW), .DW(DW), .LANE_W(LANE_W)) u_match (
      .check   (pop),
      .a_addr  (head_addr),
      .a_data  (head_data),
      .b_addr  (trail_addr),
      .b_data  (trail_data),
      .verdict (verdict)
   );

   spc_release #(.AW(AW), .DW(DW)) u_release (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .addr_in   (head_addr),
      .data_in   (head_data),
      .mem_ready (mem_ready),
      .mem_valid (mem_valid),
      .mem_addr  (mem_addr),
      .mem_data  (mem_data),
      .slot_free (slot_free)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)                         fault <= 1'b0;
      else if (verdict == VERDICT_DIFFER) fault <= 1'b1;
   end
endmodule

module spc_props #(
   parameter int AW    = 32,
   parameter int DW    = 32,
   parameter int DEPTH = 4,
   parameter int CW    = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic          lead_ready,
   input logic          trail_valid,
   input logic          trail_ready,
   input logic          mem_valid,
   input logic          mem_ready,
   input logic [AW-1:0] mem_addr,
   input logic [DW-1:0] mem_data,
   input logic          fault,
   input logic [CW-1:0] occ
);
   // R2
   full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (occ == CW'(DEPTH)) |-> !lead_ready);

   // R3
   trail_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trail_ready |-> (occ != '0) && (!mem_valid || mem_ready));

   // R5
   release_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_valid) |-> $past(trail_valid && trail_ready));

   // R6
   fault_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fault) |-> $past(trail_valid && trail_ready));

   // R7
   fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault |=> fault);

   // R7
   no_release_after_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fault && !mem_valid) |=> !mem_valid);

   // R8
   hold_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !mem_ready) |=> mem_valid && $stable(mem_addr) && $stable(mem_data));
endmodule

bind store_pair_checker spc_props #(
   .AW(AW), .DW(DW), .DEPTH(DEPTH), .CW($clog2(DEPTH + 1))
) u_props (
   .clk         (clk),
   .rst_n       (rst_n),
   .lead_ready  (lead_ready),
   .trail_valid (trail_valid),
   .trail_ready (trail_ready),
   .mem_valid   (mem_valid),
   .mem_ready   (mem_ready),
   .mem_addr    (mem_addr),
   .mem_data    (mem_data),
   .fault       (fault),
   .occ         (occ)
);

// File: tb/tb_store_pair_checker.sv
module tb_store_pair_checker;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 32;
   localparam int DW = 32;
   localparam int DEPTH = 4;
   localparam int NV = 6;
   localparam logic [63:0] VECS [NV] = '{
      64'h0000_0000_0000_0000,
      64'hFFFF_FFFC_FFFF_FFFF,
      64'h5555_5554_AAAA_AAAA,
      64'h1000_0040_DEAD_BEEF,
      64'h8000_0000_0000_0001,
      64'h0BAD_F00C_1234_5678
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic lead_valid = 1'b0, trail_valid = 1'b0, mem_ready = 1'b0;
   logic [AW-1:0] lead_addr = '0, trail_addr = '0;
   logic [DW-1:0] lead_data = '0, trail_data = '0;
   logic lead_ready, trail_ready, mem_valid, fault;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_data;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   store_pair_checker #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) dut (
      .clk(clk), .rst_n(rst_n),
      .lead_valid(lead_valid), .lead_ready(lead_ready),
      .lead_addr(lead_addr), .lead_data(lead_data),
      .trail_valid(trail_valid), .trail_ready(trail_ready),
      .trail_addr(trail_addr), .trail_data(trail_data),
      .mem_valid(mem_valid), .mem_ready(mem_ready),
      .mem_addr(mem_addr), .mem_data(mem_data),
      .fault(fault)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; lead_valid = 1'b0; trail_valid = 1'b0; mem_ready = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic push_lead(input logic [63:0] v);
      lead_valid = 1'b1; lead_addr = v[63:32]; lead_data = v[31:0];
      @(negedge clk);
      lead_valid = 1'b0;
   endtask

   task automatic set_trail(input logic [63:0] v);
      trail_valid = 1'b1; trail_addr = v[63:32]; trail_data = v[31:0];
   endtask

   initial begin
      do_reset();
      // R1: state right after reset release
      chk(mem_valid == 1'b0, "R1 mem_valid", 64'(mem_valid), 0);
      chk(fault == 1'b0, "R1 fault", 64'(fault), 0);
      chk(lead_ready == 1'b1, "R1 lead_ready", 64'(lead_ready), 1);
      chk(trail_ready == 1'b0, "R1 trail_ready", 64'(trail_ready), 0);

      // R5 table walk: matching pairs released with the agreed store
      mem_ready = 1'b1;
      for (int i = 0; i < NV; i++) begin
         push_lead(VECS[i]);
         chk(trail_ready == 1'b1, "R3 trail_ready with waiting store", 64'(trail_ready), 1);
         set_trail(VECS[i]);
         @(negedge clk);
         trail_valid = 1'b0;
         chk(mem_valid == 1'b1, "R5 mem_valid", 64'(mem_valid), 1);
         chk({mem_addr, mem_data} == VECS[i], "R5 released store", {mem_addr, mem_data}, VECS[i]);
         chk(fault == 1'b0, "R5 no fault", 64'(fault), 0);
         @(negedge clk);
         chk(mem_valid == 1'b0, "R5 drained", 64'(mem_valid), 0);
      end

      // R2 fill the queue, R4 order, R8 hold while stalled
      mem_ready = 1'b0;
      for (int i = 0; i < DEPTH; i++) push_lead(VECS[i+1]);
      chk(lead_ready == 1'b0, "R2 lead_ready at full", 64'(lead_ready), 0);
      set_trail(VECS[1]);
      @(negedge clk);
      chk({mem_addr, mem_data} == VECS[1], "R4 first out", {mem_addr, mem_data}, VECS[1]);
      chk(trail_ready == 1'b0, "R3 slot busy", 64'(trail_ready), 0);
      chk(lead_ready == 1'b1, "R2 room after pop", 64'(lead_ready), 1);
      set_trail(VECS[2]);
      @(negedge clk);
      chk(mem_valid == 1'b1 && {mem_addr, mem_data} == VECS[1], "R8 held output",
          {mem_addr, mem_data}, VECS[1]);
      mem_ready = 1'b1;
      for (int i = 2; i <= DEPTH; i++) begin
         set_trail(VECS[i]);
         @(negedge clk);
         chk({mem_addr, mem_data} == VECS[i], "R4 order", {mem_addr, mem_data}, VECS[i]);
      end
      trail_valid = 1'b0;
      @(negedge clk);
      chk(mem_valid == 1'b0, "R5 drained after burst", 64'(mem_valid), 0);

      // R9 trailing store with nothing waiting, and lone leading store
      set_trail(VECS[3]);
      chk(trail_ready == 1'b0, "R9 trail not taken on empty", 64'(trail_ready), 0);
      @(negedge clk);
      trail_valid = 1'b0;
      chk(mem_valid == 1'b0, "R9 nothing released on empty", 64'(mem_valid), 0);
      push_lead(VECS[5]);
      repeat (3) @(negedge clk);
      chk(mem_valid == 1'b0, "R9 lone lead store held back", 64'(mem_valid), 0);

      // R6 address mismatch
      do_reset();
      mem_ready = 1'b1;
      push_lead(VECS[3]);
      set_trail(VECS[3] ^ 64'h0000_0004_0000_0000);
      @(negedge clk);
      trail_valid = 1'b0;
      chk(fault == 1'b1, "R6 address mismatch fault", 64'(fault), 1);
      chk(mem_valid == 1'b0, "R6 mismatched store dropped", 64'(mem_valid), 0);

      // R7 sticky, no later release
      push_lead(VECS[4]);
      set_trail(VECS[4]);
      @(negedge clk);
      trail_valid = 1'b0;
      chk(mem_valid == 1'b0, "R7 no release after fault", 64'(mem_valid), 0);
      chk(fault == 1'b1, "R7 fault sticky", 64'(fault), 1);
      do_reset();
      chk(fault == 1'b0, "R7 reset clears fault", 64'(fault), 0);

      // R6 data mismatch (single bit)
      mem_ready = 1'b1;
      push_lead(VECS[2]);
      set_trail(VECS[2] ^ 64'h0000_0000_0001_0000);
      @(negedge clk);
      trail_valid = 1'b0;
      chk(fault == 1'b1, "R6 data mismatch fault", 64'(fault), 1);
      chk(mem_valid == 1'b0, "R6 data mismatch dropped", 64'(mem_valid), 0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule